// File: doc/BRIEF.md
# Wiper Register Command Controller

This block sits behind a serial two-wire target. It turns the target's decoded events into register operations on a 7-bit wiper code and a 7-bit nonvolatile data register. The target tells the block when a bus transaction starts or stops, when its own address has matched (and with which command type), and when a byte has arrived after that. In stepping mode it also reports each sampled data bit.

An indirect access register picks which of the two storage registers the ordinary write and read commands act on. A direct write to the wiper changes the output code at once. A write to the data register starts a fixed busy interval at the following STOP. A stepping command moves the wiper by one position for every clocked bit and clamps it at both ends. At reset the wiper is taken from the data register, so the output starts at the stored position.

Top module: `wiper_cmd_ctrl`

## Requirements
- R1: A write command whose first byte is 02h makes the next byte the access-register value. 80h selects the wiper register and 00h selects the data register. Any other value leaves the selection unchanged. After reset the wiper register is selected.
- R2: A write command whose first byte is 00h makes the next byte the new value of the selected register. Further bytes before STOP are ignored.
- R3: Both registers hold 7 bits. Bit 7 of a written byte is discarded, and bit 7 of read data is always 0.
- R4: After reset the data register holds parameter DR_INIT. From the first clock after reset release, the wiper equals the data register's value.
- R5: In a stepping command (sel_cmd = 10), once the first byte is 00h, every bit strobe with bit_in = 1 raises the wiper by one and every strobe with bit_in = 0 lowers it by one. The new value appears in the cycle after the strobe.
- R6: Stepping saturates at 0 and 127 and never rolls over. The last position is kept after STOP.
- R7: A read command (sel_cmd = 01) that follows a write command with first byte 00h, with no STOP in between, loads rd_data with the selected register zero-extended. A read command without such a pointer leaves rd_data unchanged.
- R8: A wiper write appears on `wiper` in the cycle after the data byte strobe and never raises busy.
- R9: A data-register write raises busy in the cycle after the next STOP. Busy then stays high for exactly BUSY_CYC cycles.
- R10: A first byte other than 00h or 02h is ignored. The bytes that follow it change no register before STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_evt | input | 1 | START or repeated START seen on the bus |
| stop_evt | input | 1 | STOP seen on the bus |
| sel_vld | input | 1 | Target address matched; sel_cmd is valid |
| sel_cmd | input | 2 | Command type: 00 write, 01 read, 10 stepping |
| byte_vld | input | 1 | A byte after the address byte has been received |
| byte_in | input | 8 | Received byte |
| bit_vld | input | 1 | Sampled data bit strobe for stepping mode |
| bit_in | input | 1 | Sampled data bit value |
| rd_data | output | 8 | Byte returned for a read command |
| busy | output | 1 | Nonvolatile write interval in progress |
| wiper | output | 7 | Current wiper code |

## Verification
The embedded assertions watch four things on every cycle. They check that stepping clamps at both ends, that the wiper follows the data register on the load after reset, that busy rises after a STOP that closes a data-register write and holds while the counter runs, and that a wiper write never raises busy. The directed scenarios are needed for the rest. Only they show the indirect selection through the access register, the ignored addresses and access values, the read pointer lasting across a repeated START but not across a STOP, the discarded bit 7, and the exact length of the busy interval.

// File: rtl/wcc_pkg.sv
package wcc_pkg;
  typedef enum logic [1:0] {
    CMD_WRITE = 2'b00,
    CMD_READ  = 2'b01,
    CMD_STEP  = 2'b10
  } cmd_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_ACCESS,
    S_DATA,
    S_STEP,
    S_DONE
  } dec_state_e;
endpackage

// File: rtl/wcc_decode.sv
module wcc_decode
  import wcc_pkg::*;
#(
  parameter int WW        = 7,
  parameter int BW        = 8,
  parameter logic [7:0] ACC_ADDR  = 8'h02,
  parameter logic [7:0] REG_ADDR  = 8'h00,
  parameter logic [7:0] SEL_WIPER = 8'h80,
  parameter logic [7:0] SEL_DATA  = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic          sel_vld,
  input  logic [1:0]    sel_cmd,
  input  logic          byte_vld,
  input  logic [BW-1:0] byte_in,
  input  logic          bit_vld,
  input  logic          bit_in,
  input  logic [WW-1:0] wiper_q,
  input  logic [WW-1:0] dr_q,
  output logic          wip_wr,
  output logic          dr_wr,
  output logic [WW-1:0] wr_val,
  output logic          step_en,
  output logic          step_up,
  output logic [BW-1:0] rd_data
);
  dec_state_e state_q, state_d;
  logic       step_mode_q, step_mode_d;
  logic       ptr_q, ptr_d;
  logic       acc_wiper_q, acc_wiper_d;
  logic [BW-1:0] rd_q, rd_d;
  logic [WW-1:0] sel_val;

  assign sel_val = acc_wiper_q ? wiper_q : dr_q;
  assign wr_val  = byte_in[WW-1:0];

  always_comb begin
    state_d     = state_q;
    step_mode_d = step_mode_q;
    ptr_d       = ptr_q;
    acc_wiper_d = acc_wiper_q;
    rd_d        = rd_q;
    wip_wr      = 1'b0;
    dr_wr       = 1'b0;
    step_en     = 1'b0;
    step_up     = bit_in;
    if (stop_evt) begin
      state_d = S_IDLE;
      ptr_d   = 1'b0;
    end else if (start_evt) begin
      state_d = S_IDLE;
    end else if (sel_vld) begin
      case (cmd_e'(sel_cmd))
        CMD_WRITE: begin
          state_d     = S_ADDR;
          step_mode_d = 1'b0;
        end
        CMD_STEP: begin
          state_d     = S_ADDR;
          step_mode_d = 1'b1;
        end
        CMD_READ: begin
          state_d = S_DONE;
          if (ptr_q) rd_d = {{(BW-WW){1'b0}}, sel_val};
        end
        default: state_d = S_DONE;
      endcase
    end else begin
      case (state_q)
        S_ADDR: if (byte_vld) begin
          if (byte_in == REG_ADDR) begin
            state_d = step_mode_q ? S_STEP : S_DATA;
            ptr_d   = !step_mode_q;
          end else if (byte_in == ACC_ADDR && !step_mode_q) begin
            state_d = S_ACCESS;
          end else begin
            state_d = S_DONE;
          end
        end
        S_ACCESS: if (byte_vld) begin
          if (byte_in == SEL_WIPER) acc_wiper_d = 1'b1;
          else if (byte_in == SEL_DATA) acc_wiper_d = 1'b0;
          state_d = S_DONE;
        end
        S_DATA: if (byte_vld) begin
          wip_wr  = acc_wiper_q;
          dr_wr   = !acc_wiper_q;
          state_d = S_DONE;
        end
        S_STEP: step_en = bit_vld;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      step_mode_q <= 1'b0;
      ptr_q       <= 1'b0;
      acc_wiper_q <= 1'b1;
      rd_q        <= '0;
    end else begin
      state_q     <= state_d;
      step_mode_q <= step_mode_d;
      ptr_q       <= ptr_d;
      acc_wiper_q <= acc_wiper_d;
      rd_q        <= rd_d;
    end
  end

  assign rd_data = rd_q;

  // R3: read data never carries a bit above the register width
  assert_rd_msb_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_q[BW-1] == 1'b0);

  // R2: at most one register is written per byte
  assert_single_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wip_wr && dr_wr));
endmodule

// File: rtl/wcc_wiper.sv
module wcc_wiper #(
  parameter int WW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [WW-1:0] dr_q,
  input  logic          wr_en,
  input  logic [WW-1:0] wr_val,
  input  logic          step_en,
  input  logic          step_up,
  output logic [WW-1:0] wiper_q
);
  localparam logic [WW-1:0] WMAX = '1;
  localparam logic [WW-1:0] WMIN = '0;

  logic          loaded_q, loaded_d;
  logic [WW-1:0] wip_q, wip_d;
  logic          wip_en;

  always_comb begin
    wip_d    = wip_q;
    loaded_d = 1'b1;
    wip_en   = 1'b0;
    if (!loaded_q) begin
      wip_d  = dr_q;
      wip_en = 1'b1;
    end else if (wr_en) begin
      wip_d  = wr_val;
      wip_en = 1'b1;
    end else if (step_en) begin
      if (step_up && wip_q != WMAX) begin
        wip_d  = wip_q + 1'b1;
        wip_en = 1'b1;
      end else if (!step_up && wip_q != WMIN) begin
        wip_d  = wip_q - 1'b1;
        wip_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
      wip_q    <= '0;
    end else begin
      loaded_q <= loaded_d;
      if (wip_en) wip_q <= wip_d;
    end
  end

  assign wiper_q = wip_q;

  assert_load_from_dr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded_q |=> wip_q == $past(dr_q));

  assert_sat_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && !wr_en && step_en && step_up && wip_q == WMAX) |=> wip_q == WMAX);

  assert_sat_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && !wr_en && step_en && !step_up && wip_q == WMIN) |=> wip_q == WMIN);

  assert_step_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && !wr_en && step_en && step_up && wip_q != WMAX) |=> wip_q == $past(wip_q) + 1'b1);
endmodule

// File: rtl/wcc_nvreg.sv
module wcc_nvreg #(
  parameter int WW        = 7,
  parameter int BUSY_CYC  = 200,
  parameter logic [WW-1:0] DR_INIT = 7'd64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dr_wr,
  input  logic [WW-1:0] wr_val,
  input  logic          stop_evt,
  output logic [WW-1:0] dr_q,
  output logic          busy
);
  localparam int CW = $clog2(BUSY_CYC + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(BUSY_CYC);

  logic [WW-1:0] data_q;
  logic          pend_q, pend_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    pend_d = pend_q;
    cnt_d  = cnt_q;
    if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    if (dr_wr) pend_d = 1'b1;
    if (stop_evt && (pend_q || dr_wr)) begin
      pend_d = 1'b0;
      cnt_d  = CNT_LOAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= DR_INIT;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (dr_wr) data_q <= wr_val;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  assign dr_q = data_q;
  assign busy = (cnt_q != '0);

  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && pend_q) |=> busy);

  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q > CW'(1)) |=> busy);
endmodule

// File: rtl/wiper_cmd_ctrl.sv
module wiper_cmd_ctrl #(
  parameter int WW       = 7,
  parameter int BW       = 8,
  parameter int BUSY_CYC = 200,
  parameter logic [WW-1:0] DR_INIT = 7'd64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic          sel_vld,
  input  logic [1:0]    sel_cmd,
  input  logic          byte_vld,
  input  logic [BW-1:0] byte_in,
  input  logic          bit_vld,
  input  logic          bit_in,
  output logic [BW-1:0] rd_data,
  output logic          busy,
  output logic [WW-1:0] wiper
);
  logic          wip_wr, dr_wr, step_en, step_up;
  logic [WW-1:0] wr_val, dr_q, wiper_q;

  wcc_decode #(.WW(WW), .BW(BW)) u_dec (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
    .sel_vld(sel_vld), .sel_cmd(sel_cmd), .byte_vld(byte_vld), .byte_in(byte_in),
    .bit_vld(bit_vld), .bit_in(bit_in), .wiper_q(wiper_q), .dr_q(dr_q),
    .wip_wr(wip_wr), .dr_wr(dr_wr), .wr_val(wr_val), .step_en(step_en),
    .step_up(step_up), .rd_data(rd_data)
  );

  wcc_wiper #(.WW(WW)) u_wip (
    .clk(clk), .rst_n(rst_n), .dr_q(dr_q), .wr_en(wip_wr), .wr_val(wr_val),
    .step_en(step_en), .step_up(step_up), .wiper_q(wiper_q)
  );

  wcc_nvreg #(.WW(WW), .BUSY_CYC(BUSY_CYC), .DR_INIT(DR_INIT)) u_nv (
    .clk(clk), .rst_n(rst_n), .dr_wr(dr_wr), .wr_val(wr_val),
    .stop_evt(stop_evt), .dr_q(dr_q), .busy(busy)
  );

  assign wiper = wiper_q;

  assert_wiper_write_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wip_wr && !busy) |=> !busy);
endmodule

// File: tb/sim_wiper_cmd_ctrl.sv
module sim_wiper_cmd_ctrl;
  logic       clk, rst_n;
  logic       start_evt, stop_evt, sel_vld, byte_vld, bit_vld, bit_in;
  logic [1:0] sel_cmd;
  logic [7:0] byte_in;
  logic [7:0] rd_data;
  logic       busy;
  logic [6:0] wiper;
  int total = 0;
  int bad = 0;
  bit done = 0;

  localparam int BUSY_N = 200;

  wiper_cmd_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
    .sel_vld(sel_vld), .sel_cmd(sel_cmd), .byte_vld(byte_vld), .byte_in(byte_in),
    .bit_vld(bit_vld), .bit_in(bit_in), .rd_data(rd_data), .busy(busy), .wiper(wiper)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_in();
    start_evt = 0; stop_evt = 0; sel_vld = 0; byte_vld = 0; bit_vld = 0;
  endtask

  task automatic do_start();
    @(negedge clk); idle_in(); start_evt = 1; @(negedge clk); idle_in();
  endtask
  task automatic do_stop();
    @(negedge clk); idle_in(); stop_evt = 1; @(negedge clk); idle_in();
  endtask
  task automatic do_sel(logic [1:0] c);
    @(negedge clk); idle_in(); sel_vld = 1; sel_cmd = c; @(negedge clk); idle_in();
  endtask
  task automatic do_byte(logic [7:0] b);
    @(negedge clk); idle_in(); byte_vld = 1; byte_in = b; @(negedge clk); idle_in();
  endtask
  task automatic do_bit(logic v);
    @(negedge clk); idle_in(); bit_vld = 1; bit_in = v; @(negedge clk); idle_in();
  endtask

  task automatic access(logic [7:0] v);
    do_start(); do_sel(2'b00); do_byte(8'h02); do_byte(v); do_stop();
  endtask
  task automatic write_reg(logic [7:0] v);
    do_start(); do_sel(2'b00); do_byte(8'h00); do_byte(v); do_stop();
  endtask
  task automatic read_reg();
    do_start(); do_sel(2'b00); do_byte(8'h00); do_start(); do_sel(2'b01);
  endtask

  task automatic t_reset();
    check("R4 wiper from data reg", wiper, 64);
    check("R9 busy idle after reset", busy, 0);
    check("R7 rd_data reset", rd_data, 0);
  endtask

  task automatic t_wiper_write();
    do_start(); do_sel(2'b00); do_byte(8'h00); do_byte(8'hA5);
    check("R8 wiper updated next cycle", wiper, 8'h25);
    check("R8 no busy", busy, 0);
    do_byte(8'h11);
    check("R2 extra byte ignored", wiper, 8'h25);
    do_stop();
    check("R8 no busy after stop", busy, 0);
    read_reg();
    check("R3 read msb zero", rd_data, 8'h25);
    do_stop();
  endtask

  task automatic t_read_no_ptr();
    write_reg(8'h0A);
    do_start(); do_sel(2'b01);
    check("R7 read without pointer keeps rd_data", rd_data, 8'h25);
    do_stop();
    read_reg();
    check("R7 read with pointer", rd_data, 8'h0A);
    do_stop();
  endtask

  task automatic t_step();
    write_reg(8'd50);
    do_start(); do_sel(2'b10); do_byte(8'h00);
    do_bit(1); check("R5 step up", wiper, 51);
    do_bit(1); do_bit(0); do_bit(1);
    check("R5 mixed steps", wiper, 52);
    do_stop();
    check("R6 position kept after stop", wiper, 52);
  endtask

  task automatic t_sat();
    write_reg(8'd120);
    do_start(); do_sel(2'b10); do_byte(8'h00);
    for (int i = 0; i < 10; i++) do_bit(1);
    check("R6 saturate high", wiper, 127);
    do_stop();
    write_reg(8'd2);
    do_start(); do_sel(2'b10); do_byte(8'h00);
    for (int i = 0; i < 5; i++) do_bit(0);
    check("R6 saturate low", wiper, 0);
    do_bit(1);
    check("R5 step up from floor", wiper, 1);
    do_stop();
  endtask

  task automatic t_dr_busy();
    int n;
    access(8'h00);
    do_start(); do_sel(2'b00); do_byte(8'h00); do_byte(8'h95);
    check("R1 wiper untouched by data reg write", wiper, 1);
    check("R9 no busy before stop", busy, 0);
    @(negedge clk); idle_in(); stop_evt = 1; @(negedge clk); idle_in();
    check("R9 busy rises after stop", busy, 1);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    check("R9 busy length", n, BUSY_N);
    read_reg();
    check("R3 data reg read", rd_data, 8'h15);
    do_stop();
  endtask

  task automatic t_ignore();
    access(8'h41);
    read_reg();
    check("R1 bad access value keeps selection", rd_data, 8'h15);
    do_stop();
    access(8'h80);
    read_reg();
    check("R1 wiper selected", rd_data, 1);
    do_stop();
    do_start(); do_sel(2'b00); do_byte(8'h05); do_byte(8'h00); do_byte(8'h33);
    check("R10 unknown address ignored", wiper, 1);
    do_stop();
    read_reg();
    check("R10 selection unchanged", rd_data, 1);
    do_stop();
    check("R10 no busy", busy, 0);
  endtask

  initial begin
    idle_in(); sel_cmd = 0; byte_in = 0; bit_in = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_wiper_write();
    t_read_no_ptr();
    t_step();
    t_sat();
    t_dr_busy();
    t_ignore();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule